// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is a single eight-pin general-purpose I/O port that sits behind a simple word-addressed register bus. Each pin can be an input or an output on its own. The pin data register does not live at one address. It is spread over a window of 256 words, and the eight word-address bits that select a word inside that window act as a per-pin mask. A write changes only the pins whose mask bit is set, so firmware can set or clear a single pin in one store, with no read-modify-write. A read returns zero for every pin whose mask bit is clear.

Each pin can also raise an interrupt. Per-pin configuration selects edge or level sensing, the active edge or level, and an option to fire on both edges. Edge events latch into a raw status bit that software clears by writing a one. A level-sensed status bit follows the synchronized pin for as long as the active level holds. A per-pin enable mask gates the raw status onto the single interrupt line. Pin inputs pass through a two-flop synchronizer before any of this logic sees them.

Top module: `gpio_masked_port`

## Requirements
- R1: While reset is held (synchronous, active high), every configuration register, the output data register and the edge latches go to zero. After reset, `pin_out`, `pin_oe` and `irq` are 0.
- R2: `pin_oe[i]` equals bit i of the direction register, where 1 means output. The direction register is at word offset 0 of the config window.
- R3: The data window is the set of word addresses with `bus_addr[11:10]` = 0, and the mask is `bus_addr[9:2]`. A write there loads `pin_out[i]` from `bus_wdata[i]` only where mask bit i is 1, and every other bit keeps its value.
- R4: A read in the data window returns, for each pin whose mask bit is 1, the output register bit if the pin is an output and the synchronized input if it is an input. Pins whose mask bit is 0 read as 0.
- R5: A change on `pin_in` shows up in data reads after exactly two rising clock edges, and not after one.
- R6: In edge mode (sense bit 0), the raw status bit is set by a rising edge when the polarity bit is 1 and by a falling edge when it is 0. It stays set until it is cleared.
- R7: When the both-edges bit is 1 in edge mode, both rising and falling edges set the raw status bit, whatever the polarity bit says.
- R8: In level mode (sense bit 1), the raw status bit is 1 exactly while the synchronized pin equals the polarity bit. Writing ones to the status register has no effect on it.
- R9: Writing the raw status register (config offset 5) clears the edge-mode bits where the write data is 1. Bits written 0 keep their value.
- R10: `irq` is 1 exactly when some pin has both its raw status bit and its interrupt enable bit (offset 4) set. The masked status register (offset 6) reads raw AND enable.
- R11: The config window is the set of word addresses with `bus_addr[11:10]` = 1 and `bus_addr[9:6]` = 0. Offsets in `bus_addr[5:2]` are: 0 direction, 1 sense, 2 polarity, 3 both-edges, 4 interrupt enable. Each reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe; a write takes effect at the rising edge |
| bus_addr | input | 10 | Word address, bits [11:2] of the byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output data register |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench writes with partial masks and with an empty mask. A design that decoded the mask from the wrong address bits, or that let data through unmasked, would corrupt the neighbouring pins. Reads use sparse masks on a port that mixes inputs and outputs, which catches a read mux that ignores direction or leaks masked bits. It counts the synchronizer latency edge by edge, so one flop too few or too many shows up. Separate pins in rising, falling and both-edges mode catch a swapped polarity. Writing ones to level-sensed pins and zeros to latched pins catches a clear that reaches the wrong bits or drops a level status.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned PINS = 8;

    typedef logic [PINS-1:0] pinvec_t;

    typedef enum logic [3:0] {
        OFS_DIR   = 4'd0,
        OFS_SENSE = 4'd1,
        OFS_POL   = 4'd2,
        OFS_BOTH  = 4'd3,
        OFS_IMASK = 4'd4,
        OFS_RAW   = 4'd5,
        OFS_MIS   = 4'd6
    } cfg_ofs_e;

    typedef struct packed {
        pinvec_t dir;
        pinvec_t sense;
        pinvec_t pol;
        pinvec_t both;
        pinvec_t imask;
    } cfg_t;

    function automatic pinvec_t masked_merge(pinvec_t cur, pinvec_t nxt, pinvec_t sel);
        return (cur & ~sel) | (nxt & sel);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:2] bus_addr,
    input  pinvec_t           bus_wdata,
    input  pinvec_t           in_sync,
    input  pinvec_t           raw,
    output cfg_t              cfg,
    output pinvec_t           out_q,
    output pinvec_t           clr_mask,
    output pinvec_t           rdata
);
    localparam int unsigned RLO = PINS + 2;

    logic [ADDR_W-1:RLO] region;
    pinvec_t             amask;
    cfg_ofs_e            ofs;
    logic                data_hit, cfg_hit;
    pinvec_t             pin_val;

    assign region   = bus_addr[ADDR_W-1:RLO];
    assign amask    = bus_addr[RLO-1:2];
    assign ofs      = cfg_ofs_e'(bus_addr[5:2]);
    assign data_hit = (region == '0);
    assign cfg_hit  = (region == 1) && (bus_addr[RLO-1:6] == '0);
    assign pin_val  = (cfg.dir & out_q) | (~cfg.dir & in_sync);
    assign clr_mask = (bus_wr && cfg_hit && ofs == OFS_RAW) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            out_q <= '0;
        end else if (bus_wr) begin
            if (data_hit) begin
                out_q <= masked_merge(out_q, bus_wdata, amask);
            end else if (cfg_hit) begin
                case (ofs)
                    OFS_DIR:   cfg.dir   <= bus_wdata;
                    OFS_SENSE: cfg.sense <= bus_wdata;
                    OFS_POL:   cfg.pol   <= bus_wdata;
                    OFS_BOTH:  cfg.both  <= bus_wdata;
                    OFS_IMASK: cfg.imask <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (data_hit) begin
            rdata = pin_val & amask;
        end else if (cfg_hit) begin
            case (ofs)
                OFS_DIR:   rdata = cfg.dir;
                OFS_SENSE: rdata = cfg.sense;
                OFS_POL:   rdata = cfg.pol;
                OFS_BOTH:  rdata = cfg.both;
                OFS_IMASK: rdata = cfg.imask;
                OFS_RAW:   rdata = raw;
                OFS_MIS:   rdata = raw & cfg.imask;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pinvec_t s,
    input  pinvec_t sense,
    input  pinvec_t pol,
    input  pinvec_t both,
    input  pinvec_t imask,
    input  pinvec_t clr_mask,
    output pinvec_t raw,
    output logic    irq
);
    pinvec_t s_d;
    pinvec_t latch_q;

    always_ff @(posedge clk) begin
        if (rst) s_d <= '0;
        else     s_d <= s;
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic rise, fall, hit, lat;

        assign rise = s[i] & ~s_d[i];
        assign fall = ~s[i] & s_d[i];
        assign hit  = both[i] ? (rise | fall) : (pol[i] ? rise : fall);

        always_ff @(posedge clk) begin
            if (rst)                         lat <= 1'b0;
            else if (!sense[i] && hit)       lat <= 1'b1;
            else if (sense[i] || clr_mask[i]) lat <= 1'b0;
        end

        assign latch_q[i] = lat;
        assign raw[i]     = sense[i] ? (s[i] == pol[i]) : latch_q[i];
    end

    assign irq = |(raw & imask);
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:2] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    cfg_t    cfg;
    pinvec_t in_sync, raw, clr_mask, out_q;

    gpio_sync #(.W(PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    gpio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .in_sync  (in_sync),
        .raw      (raw),
        .cfg      (cfg),
        .out_q    (out_q),
        .clr_mask (clr_mask),
        .rdata    (bus_rdata)
    );

    gpio_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .s       (in_sync),
        .sense   (cfg.sense),
        .pol     (cfg.pol),
        .both    (cfg.both),
        .imask   (cfg.imask),
        .clr_mask(clr_mask),
        .raw     (raw),
        .irq     (irq)
    );

    assign pin_out = out_q;
    assign pin_oe  = cfg.dir;
endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:2] bus_addr,
    input pinvec_t           bus_wdata,
    input pinvec_t           pin_out,
    input pinvec_t           pin_oe,
    input logic              irq,
    input pinvec_t           raw,
    input pinvec_t           sense,
    input pinvec_t           imask
);
    localparam int unsigned RLO = PINS + 2;

    logic    data_wr, clr_wr;
    pinvec_t amask, hold;

    assign data_wr = bus_wr && (bus_addr[ADDR_W-1:RLO] == '0);
    assign clr_wr  = bus_wr && (bus_addr[ADDR_W-1:RLO] == 1) &&
                     (bus_addr[RLO-1:6] == '0) && (bus_addr[5:2] == 4'd5);
    assign amask   = bus_addr[RLO-1:2];
    assign hold    = raw & ~sense & ~(clr_wr ? bus_wdata : '0);

    // R1: outputs quiet in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0 && !irq));

    // R3: masked data write touches only selected pins
    a_r3_masked_write: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> pin_out == ((($past(pin_out)) & ~$past(amask)) |
                                ($past(bus_wdata) & $past(amask))));

    // R6: latched edge status survives unless cleared
    a_r6_edge_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((raw | sense) & $past(hold)) == $past(hold)));

    // R10: interrupt only with an enabled raw status
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((raw & imask) != '0));
endmodule

bind gpio_masked_port gpio_masked_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .raw      (raw),
    .sense    (cfg.sense),
    .imask    (cfg.imask)
);

// File: tb/gpio_masked_port_tb.sv
module gpio_masked_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [11:2] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_masked_port u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [11:2] daddr(logic [7:0] m);
        return {2'b00, m};
    endfunction

    function automatic logic [11:2] caddr(logic [3:0] o);
        return {2'b01, 4'b0000, o};
    endfunction

    task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic wr(logic [11:2] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:2] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drive_pins(logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "pin_out", pin_out, 8'h00);
        chk("R1", "pin_oe", pin_oe, 8'h00);
        chk("R1", "irq", {7'b0, irq}, 8'h00);
        rd(caddr(4'd1), v);
        chk("R1", "sense reg", v, 8'h00);
    endtask

    task automatic t_dir_cfg();
        logic [7:0] v;
        wr(caddr(4'd0), 8'hF0);
        chk("R2", "pin_oe", pin_oe, 8'hF0);
        rd(caddr(4'd0), v);
        chk("R11", "dir readback", v, 8'hF0);
        wr(caddr(4'd3), 8'h5A);
        rd(caddr(4'd3), v);
        chk("R11", "both readback", v, 8'h5A);
        wr(caddr(4'd3), 8'h00);
    endtask

    task automatic t_masked_write();
        wr(daddr(8'hFF), 8'hA5);
        chk("R3", "full mask", pin_out, 8'hA5);
        wr(daddr(8'h0F), 8'h00);
        chk("R3", "low nibble mask", pin_out, 8'hA0);
        wr(daddr(8'h00), 8'hFF);
        chk("R3", "empty mask", pin_out, 8'hA0);
        wr(daddr(8'h42), 8'hFF);
        chk("R3", "sparse mask", pin_out, 8'hE2);
        wr(daddr(8'h42), 8'h00);
    endtask

    task automatic t_masked_read();
        logic [7:0] v;
        drive_pins(8'h3C);
        rd(daddr(8'hFF), v);
        chk("R4", "mixed dir read", v, 8'hAC);
        rd(daddr(8'h81), v);
        chk("R4", "sparse read", v, 8'h80);
        rd(daddr(8'h00), v);
        chk("R4", "empty mask read", v, 8'h00);
    endtask

    task automatic t_sync_latency();
        logic [7:0] v;
        @(negedge clk);
        pin_in = 8'h33;
        @(negedge clk);
        rd(daddr(8'h0F), v);
        chk("R5", "after one edge", v, 8'h0C);
        @(negedge clk);
        rd(daddr(8'h0F), v);
        chk("R5", "after two edges", v, 8'h03);
    endtask

    task automatic t_edges();
        logic [7:0] v;
        wr(caddr(4'd0), 8'h00);
        drive_pins(8'h00);
        wr(caddr(4'd2), 8'h01);
        wr(caddr(4'd3), 8'h04);
        wr(caddr(4'd5), 8'hFF);
        rd(caddr(4'd5), v);
        chk("R9", "status cleared", v, 8'h00);
        drive_pins(8'h07);
        rd(caddr(4'd5), v);
        chk("R6", "rising edges", v, 8'h05);
        drive_pins(8'h00);
        rd(caddr(4'd5), v);
        chk("R7", "falling plus both", v, 8'h07);
        drive_pins(8'h07);
        rd(caddr(4'd5), v);
        chk("R6", "sticky", v, 8'h07);
    endtask

    task automatic t_clear_irq();
        logic [7:0] v;
        wr(caddr(4'd5), 8'h01);
        rd(caddr(4'd5), v);
        chk("R9", "clear bit0", v, 8'h06);
        wr(caddr(4'd5), 8'h00);
        rd(caddr(4'd5), v);
        chk("R9", "write zero", v, 8'h06);
        chk("R10", "irq disabled", {7'b0, irq}, 8'h00);
        wr(caddr(4'd4), 8'h02);
        chk("R10", "irq enabled", {7'b0, irq}, 8'h01);
        rd(caddr(4'd6), v);
        chk("R10", "masked status", v, 8'h02);
        wr(caddr(4'd5), 8'h02);
        chk("R10", "irq after clear", {7'b0, irq}, 8'h00);
        wr(caddr(4'd5), 8'hFF);
        wr(caddr(4'd4), 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] v;
        drive_pins(8'h00);
        wr(caddr(4'd5), 8'hFF);
        wr(caddr(4'd2), 8'h10);
        wr(caddr(4'd1), 8'h30);
        rd(caddr(4'd5), v);
        chk("R8", "low level active", v, 8'h20);
        drive_pins(8'h30);
        rd(caddr(4'd5), v);
        chk("R8", "high level active", v, 8'h10);
        wr(caddr(4'd5), 8'hFF);
        rd(caddr(4'd5), v);
        chk("R8", "clear ignored", v, 8'h10);
        drive_pins(8'h20);
        rd(caddr(4'd5), v);
        chk("R8", "level released", v, 8'h00);
        wr(caddr(4'd4), 8'h10);
        chk("R10", "level irq idle", {7'b0, irq}, 8'h00);
        drive_pins(8'h30);
        chk("R10", "level irq active", {7'b0, irq}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir_cfg();
        t_masked_write();
        t_masked_read();
        t_sync_latency();
        t_edges();
        t_clear_irq();
        t_level();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule